// File: doc/BRIEF.md
# Sweep Phase Sequencer

This block steps a test tone through a frequency sweep and measures the phase lag of an analog path at every step. It drives the frequency control word (FCW) of the stimulus synthesizer. It watches the sign bit of the stimulus and the sign bit of the digitized response, and treats each as a square wave at the test frequency. At each step it counts the clocks from a rising edge of the stimulus sign to the next rising edge of the response sign. It scales that count by the FCW to get a phase word, and keeps the result in a phase register.

With the phase held, the sequencer pulses a preload strobe so that the reference synthesizer restarts at the measured phase offset. It then opens a correlation window for the amplitude analyzer, lasting one full accumulation period. Next it presents the phase, a timeout flag and the FCW to the host for one cycle. Only then does it move to the next frequency. The sweep starts at the step size and climbs by that step until it reaches half the clock rate. After every frequency change, one full window of settling time passes before the next phase measurement.

Top module: `sweep_phase_seq`

## Requirements
- R1: After reset, `fcw` is 0, `ref_phase` is 0, and `busy`, `ref_load`, `corr_en`, `rpt_valid`, `rpt_timeout` and `sweep_done` are all 0. The block also returns to this idle output state after a sweep ends.
- R2: A `start` pulse while idle launches a sweep. The first step uses `fcw` = FCW_STEP, and each later step adds FCW_STEP. The last step uses `fcw` = 2^(L-1), giving 2^(L-1)/FCW_STEP steps. One cycle after the last report, `sweep_done` pulses for one cycle while `busy` and `fcw` are back at 0.
- R3: After every change of `fcw`, at least 2^L clocks of settling pass before phase measurement begins. As a result, `ref_load` is never seen sooner than 2^L + 2 cycles after the new `fcw` appears.
- R4: The measured delay is the number of clocks from a rising edge of the stimulus sign to the first later rising edge of the response sign. A response edge in the same cycle as the stimulus edge gives a delay of 0. Both inputs pass through the same number of synchronizer stages.
- R5: The stored phase is (delay × fcw) mod 2^L, an unsigned L-bit word.
- R6: The step times out in either of two cases: no stimulus rising edge within 2^L clocks of measurement start, or no response rising edge within 2^L − 1 clocks of the stimulus edge. On a timeout the stored phase is 0 and `rpt_timeout` is 1. Otherwise `rpt_timeout` is 0.
- R7: `ref_load` is a one-cycle pulse. While it is high, `ref_phase` carries the phase just measured.
- R8: `corr_en` rises in the cycle right after `ref_load` and stays high for exactly 2^L consecutive cycles.
- R9: `rpt_valid` pulses for one cycle right after `corr_en` falls. During that pulse, `ref_phase`, `rpt_timeout` and `fcw` describe the step just finished. `fcw` changes only after the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a sweep (honoured while idle) |
| stim_sign | input | 1 | Sign bit of the stimulus sine |
| resp_sign | input | 1 | Sign bit of the digitized response |
| fcw | output | L | Frequency control word for both synthesizers |
| ref_load | output | 1 | One-cycle strobe: restart reference synthesizer at `ref_phase` |
| ref_phase | output | L | Stored phase word (preload and report value) |
| corr_en | output | 1 | Amplitude correlation window enable |
| rpt_valid | output | 1 | One-cycle strobe: step result ready for the host |
| rpt_timeout | output | 1 | The reported step timed out |
| busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | One-cycle strobe after the final step |

## Verification
The bench builds the block with L = 6, FCW_STEP = 2 and SYNC = 2. This gives a 64-clock window and a 16-step sweep, so whole sweeps run many times, including the steps near Nyquist where the square wave toggles every clock. The two synchronizer stages confirm that equal input latency cancels out of the delay. The short window also keeps timeouts cheap: the response is held low on chosen steps, and the delay is pushed to its largest legal value just below the square-wave period.

// File: rtl/sps_pkg.sv
package sps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_MEASURE,
      ST_LOAD_REF,
      ST_CORRELATE,
      ST_REPORT,
      ST_NEXT
   } sps_state_e;

endpackage

// File: rtl/sps_edge.sv
module sps_edge #(
   parameter int SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic lvl;
   logic prev_q;

   generate
      if (SYNC < 0) begin : g_bad
         $error("sps_edge: SYNC must be non-negative");
      end
      if (SYNC == 0) begin : g_direct
         assign lvl = din;
      end else begin : g_sync
         logic [SYNC-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= din;
               for (int i = 1; i < SYNC; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign lvl = chain_q[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;

endmodule

// File: rtl/sps_phase_meter.sv
module sps_phase_meter #(
   parameter int L = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         stim_rise,
   input  logic         resp_rise,
   output logic         cap,
   output logic         tmo,
   output logic [L-1:0] delay
);

   logic [L-1:0] cnt_q;
   logic         armed_q;
   logic         cnt_full;

   generate
      if (L < 2) begin : g_bad
         $error("sps_phase_meter: L too small");
      end
   endgenerate

   assign cnt_full = (cnt_q == '1);

   // capture: response edge after arming, or both edges together
   assign cap   = en && (armed_q ? resp_rise : (stim_rise && resp_rise));
   assign delay = armed_q ? cnt_q : '0;
   assign tmo   = en && !cap && cnt_full && (armed_q || !stim_rise);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!armed_q && stim_rise) begin
         armed_q <= 1'b1;
         cnt_q   <= L'(1);
      end else begin
         cnt_q   <= cnt_q + L'(1);
      end
   end

   // R4
   arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(stim_rise));

   // R6
   tmo_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |-> (en && $past(en)));

endmodule

// File: rtl/sps_window.sv
module sps_window #(
   parameter int L = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   logic [L-1:0] cnt_q;

   assign last = run && (cnt_q == '1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || last) cnt_q <= '0;
      else                        cnt_q <= cnt_q + L'(1);
   end

   // R8
   window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/sweep_phase_seq.sv
module sweep_phase_seq
   import sps_pkg::*;
#(
   parameter int L        = 8,
   parameter int FCW_STEP = 2,
   parameter int SYNC     = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         stim_sign,
   input  logic         resp_sign,
   output logic [L-1:0] fcw,
   output logic         ref_load,
   output logic [L-1:0] ref_phase,
   output logic         corr_en,
   output logic         rpt_valid,
   output logic         rpt_timeout,
   output logic         busy,
   output logic         sweep_done
);

   localparam logic [L-1:0] STEP_V = L'(FCW_STEP);
   localparam logic [L-1:0] LAST_V = L'(1 << (L - 1));

   generate
      if (L < 3 || L > 24) begin : g_bad_width
         $error("sweep_phase_seq: L out of range");
      end
      if (FCW_STEP < 1 || ((1 << (L - 1)) % FCW_STEP) != 0) begin : g_bad_step
         $error("sweep_phase_seq: FCW_STEP must divide 2^(L-1)");
      end
   endgenerate

   sps_state_e   state_q;
   logic [L-1:0] fcw_q;
   logic [L-1:0] phase_q;
   logic         tmo_q;
   logic         done_q;

   // sign-bit edge detectors, identical latency on both channels
   logic [1:0] raw_sign;
   logic [1:0] rise;
   assign raw_sign = {resp_sign, stim_sign};

   generate
      for (genvar c = 0; c < 2; c++) begin : g_ch
         sps_edge #(.SYNC(SYNC)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_sign[c]),
            .rise (rise[c])
         );
      end
   endgenerate

   logic         meas_en;
   logic         meas_cap;
   logic         meas_tmo;
   logic [L-1:0] meas_delay;
   logic [L-1:0] phase_conv;

   assign meas_en = (state_q == ST_MEASURE);

   sps_phase_meter #(.L(L)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (meas_en),
      .stim_rise(rise[0]),
      .resp_rise(rise[1]),
      .cap      (meas_cap),
      .tmo      (meas_tmo),
      .delay    (meas_delay)
   );

   assign phase_conv = meas_delay * fcw_q;

   logic win_run;
   logic win_last;

   assign win_run = (state_q == ST_SETTLE) || (state_q == ST_CORRELATE);

   sps_window #(.L(L)) u_win (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (win_run),
      .last (win_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fcw_q   <= '0;
         phase_q <= '0;
         tmo_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  fcw_q   <= STEP_V;
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (win_last) state_q <= ST_MEASURE;
            end
            ST_MEASURE: begin
               if (meas_cap) begin
                  phase_q <= phase_conv;
                  tmo_q   <= 1'b0;
                  state_q <= ST_LOAD_REF;
               end else if (meas_tmo) begin
                  phase_q <= '0;
                  tmo_q   <= 1'b1;
                  state_q <= ST_LOAD_REF;
               end
            end
            ST_LOAD_REF: state_q <= ST_CORRELATE;
            ST_CORRELATE: begin
               if (win_last) state_q <= ST_REPORT;
            end
            ST_REPORT: state_q <= ST_NEXT;
            ST_NEXT: begin
               if (fcw_q == LAST_V) begin
                  fcw_q   <= '0;
                  phase_q <= '0;
                  tmo_q   <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  fcw_q   <= fcw_q + STEP_V;
                  state_q <= ST_SETTLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign fcw         = fcw_q;
   assign ref_phase   = phase_q;
   assign rpt_timeout = tmo_q;
   assign ref_load    = (state_q == ST_LOAD_REF);
   assign corr_en     = (state_q == ST_CORRELATE);
   assign rpt_valid   = (state_q == ST_REPORT);
   assign busy        = (state_q != ST_IDLE);
   assign sweep_done  = done_q;

   // R2
   fcw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && ($past(state_q) != ST_NEXT)) |-> $stable(fcw));

   // R2
   fcw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (fcw >= STEP_V && fcw <= LAST_V));

   // R8
   corr_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_load |=> corr_en);

   // R9
   report_after_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(corr_en) |-> rpt_valid);

   // R6
   timeout_zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && rpt_timeout) |-> (ref_phase == '0));

endmodule

// File: tb/sim_sweep_phase_seq.sv
module sim_sweep_phase_seq;

   localparam int LW   = 6;
   localparam int WIN  = 1 << LW;
   localparam int STEP = 2;
   localparam int LAST = WIN / 2;
   localparam int NSTEPS = LAST / STEP;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          stim_sign;
   logic          resp_sign;
   logic [LW-1:0] fcw;
   logic          ref_load;
   logic [LW-1:0] ref_phase;
   logic          corr_en;
   logic          rpt_valid;
   logic          rpt_timeout;
   logic          busy;
   logic          sweep_done;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   sweep_phase_seq #(.L(LW), .FCW_STEP(STEP), .SYNC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .stim_sign(stim_sign), .resp_sign(resp_sign),
      .fcw(fcw), .ref_load(ref_load), .ref_phase(ref_phase),
      .corr_en(corr_en), .rpt_valid(rpt_valid), .rpt_timeout(rpt_timeout),
      .busy(busy), .sweep_done(sweep_done)
   );

   task automatic chk(input string req, input int got, input int exp);
      nchk++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic int exp_phase(input int k, input int f, input bit dead);
      if (dead) return 0;
      return (k * f) % WIN;
   endfunction

   task automatic check_idle(input string tag);
      chk({tag, " R1 fcw"}, fcw, 0);
      chk({tag, " R1 busy"}, busy, 0);
      chk({tag, " R1 ref_load"}, ref_load, 0);
      chk({tag, " R1 corr_en"}, corr_en, 0);
      chk({tag, " R1 rpt_valid"}, rpt_valid, 0);
      chk({tag, " R1 ref_phase"}, ref_phase, 0);
      chk({tag, " R1 rpt_timeout"}, rpt_timeout, 0);
      chk({tag, " R1 sweep_done"}, sweep_done, 0);
   endtask

   // mode 0: random delay; mode 1: random delay with dead response steps;
   // mode 2: delay at the largest legal value for every step
   task automatic run_sweep(input int mode);
      logic [LW-1:0] acc = '0;
      logic [WIN-1:0] hist = '0;
      int cur_fcw = 0;
      int k = 0;
      bit dead = 0;
      int since = 0;
      int corr_cnt = 0;
      int exp_fcw = STEP;
      int nrep = 0;
      bit prev_ref = 0;
      bit prev_corr = 0;
      bit done = 0;
      int iter = 0;
      while (!done && iter < 20000) begin
         @(negedge clk);
         iter++;
         start = (iter == 1);
         if (int'(fcw) != cur_fcw) begin
            cur_fcw  = int'(fcw);
            since    = 0;
            corr_cnt = 0;
            if (cur_fcw != 0) begin
               int interval = WIN / cur_fcw;
               case (mode)
                  0: k = (cur_fcw == STEP) ? 0 : int'($urandom % interval);
                  1: k = int'($urandom % interval);
                  default: k = interval - 1;
               endcase
               dead = (mode == 1) &&
                      (cur_fcw == STEP || cur_fcw == LAST || ($urandom % 4) == 0);
            end
         end
         since++;
         if (ref_load) begin
            chk("R3 settle before measure", int'(since >= WIN + 2), 1);
            chk("R7 preload phase", ref_phase, exp_phase(k, cur_fcw, dead));
         end
         if (corr_en) begin
            if (!prev_corr) chk("R8 window follows preload", prev_ref, 1);
            corr_cnt++;
         end
         if (rpt_valid) begin
            chk("R8 window length", corr_cnt, WIN);
            chk("R9 report after window", prev_corr, 1);
            if (k == 0 && !dead)
               chk("R4 coincident edges", ref_phase, 0);
            chk("R5 phase word", ref_phase, exp_phase(k, cur_fcw, dead));
            chk("R6 timeout flag", rpt_timeout, dead);
            chk("R2 fcw sequence", fcw, exp_fcw);
            exp_fcw += STEP;
            nrep++;
         end
         if (sweep_done) begin
            chk("R2 step count", nrep, NSTEPS);
            chk("R2 busy clear at done", busy, 0);
            chk("R2 fcw clear at done", fcw, 0);
            done = 1;
         end
         prev_ref  = ref_load;
         prev_corr = corr_en;
         // drive the stimulus and a delayed copy as the response
         acc = acc + fcw;
         stim_sign = acc[LW-1];
         if (dead)        resp_sign = 1'b0;
         else if (k == 0) resp_sign = stim_sign;
         else             resp_sign = hist[k-1];
         hist = {hist[WIN-2:0], stim_sign};
      end
      if (!done) chk("watchdog sweep end", 0, 1);
      @(negedge clk);
      chk("R2 done is one cycle", sweep_done, 0);
      check_idle("post sweep");
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      rst_n = 1'b0;
      start = 1'b0;
      stim_sign = 1'b0;
      resp_sign = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("reset");
      run_sweep(0);
      run_sweep(1);
      run_sweep(2);
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule